// File: doc/BRIEF.md
# UART Channel Mode Router

This block steers the serial paths of one UART channel between its receiver core, its transmitter core and the external line pins. A two-bit channel mode selects one of four routings. In normal operation the two cores work on their own. In automatic echo the received line is resampled on the receive bit strobe and driven back out on the transmit pin. In local loop the transmitter's serial output is fed straight into the receiver and the transmit pin idles high. In remote loop the received line is echoed back, as in automatic echo, while the CPU sees neither receive data nor transmit status.

In both echo-type modes every bit is passed on exactly as sampled. This includes parity and stop bits, so nothing is regenerated. A break reported by the receiver core forces the transmit pin low until the receiver reports the next valid start bit. The block also gates the transmitter enable and the transmit status flags towards the CPU. It tells the receiver core whether to check parity and framing.

A requested mode is adopted only in a cycle where both cores report their line as idle, so that no character is cut short.

Top module: `uart_chmode`

## Requirements
- R1: `mode_o` resets to 00 (00 normal, 01 automatic echo, 10 local loop, 11 remote loop). It loads `mode_req_i` at a clock edge only when `rx_idle_i` and `tx_idle_i` are both 1; otherwise it holds.
- R2: In normal mode, `tx_pin_o` follows `core_tx_i` and `core_rx_o` follows `rx_pin_i`. `core_tx_en_o`, `tx_rdy_o` and `tx_emt_o` pass `tx_en_i`, `core_tx_rdy_i` and `core_tx_emt_i` through unchanged.
- R3: In modes 01 and 11 with no break pending, `tx_pin_o` shows `rx_pin_i` as sampled at the edge with `rx_tick_i` high, RETIME_DEPTH strobes earlier. The retime stages reset to 1.
- R4: In mode 01, `tx_rdy_o`, `tx_emt_o` and `core_tx_en_o` are 0. `cpu_rx_en_o`, `parity_chk_o` and `frame_chk_o` are 1.
- R5: In mode 11, `parity_chk_o`, `frame_chk_o`, `cpu_rx_en_o`, `tx_rdy_o`, `tx_emt_o` and `core_tx_en_o` are all 0.
- R6: In mode 10, `core_rx_o` follows `core_tx_i`, `tx_pin_o` is 1, and the transmit enable and status pass through.
- R7: A clock edge with `rx_break_i` high sets a break hold, and an edge with `rx_start_i` high clears it; start wins when both are high. While the hold is set in modes 01 and 11, `tx_pin_o` is 0.
- R8: In modes 01 and 11, `core_tx_i` has no effect on `tx_pin_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_req_i | input | 2 | Requested channel mode |
| rx_idle_i | input | 1 | Receiver core between characters |
| tx_idle_i | input | 1 | Transmitter core between characters |
| rx_tick_i | input | 1 | Receive bit sample strobe |
| rx_start_i | input | 1 | Receiver core saw a valid start bit |
| rx_break_i | input | 1 | Receiver core detected a break |
| rx_pin_i | input | 1 | External receive line |
| tx_pin_o | output | 1 | External transmit line |
| core_tx_i | input | 1 | Serial output of transmitter core |
| core_rx_o | output | 1 | Serial input to receiver core |
| tx_en_i | input | 1 | CPU transmitter enable |
| core_tx_en_o | output | 1 | Gated enable to transmitter core |
| core_tx_rdy_i | input | 1 | Transmitter core ready flag |
| core_tx_emt_i | input | 1 | Transmitter core empty flag |
| tx_rdy_o | output | 1 | Ready flag shown to CPU |
| tx_emt_o | output | 1 | Empty flag shown to CPU |
| parity_chk_o | output | 1 | Receiver parity check enable |
| frame_chk_o | output | 1 | Receiver framing check enable |
| cpu_rx_en_o | output | 1 | Receive data visible to CPU |
| mode_o | output | 2 | Mode in effect |

## Verification
The hardest situation to reach is a mode request that arrives while one core is still busy. It must stay pending across a stretch of echoed bits or a held break, and then land on the first cycle that both idle flags allow. The stimulus sweeps every mode in turn, toggling the idle flags and requests independently, which leaves requests pending for varying lengths. The break and start strobes are sparse and sometimes coincide, so the start-over-break priority and the retime chain contents are both observed after each mode switch.

// File: rtl/uart_chmode_pkg.sv
package uart_chmode_pkg;
  typedef enum logic [1:0] {
    CHM_NORMAL = 2'b00,
    CHM_ECHO   = 2'b01,
    CHM_LOCAL  = 2'b10,
    CHM_REMOTE = 2'b11
  } chmode_e;

  localparam int unsigned MODE_W = 2;
endpackage

// File: rtl/chmode_latch.sv
module chmode_latch
  import uart_chmode_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MODE_W-1:0]   req_i,
  input  logic                rx_idle_i,
  input  logic                tx_idle_i,
  output chmode_e             mode_o
);
  chmode_e mode_q;

  // adopt new mode only between characters on both sides
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= CHM_NORMAL;
    else if (rx_idle_i && tx_idle_i) mode_q <= chmode_e'(req_i);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/echo_retimer.sv
module echo_retimer #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic bit_i,
  input  logic brk_set_i,
  input  logic brk_clr_i,
  output logic bit_o,
  output logic brk_o
);
  logic [DEPTH-1:0] stage_q;
  logic             brk_q;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b1;
        else if (tick_i) begin
          if (g == 0) stage_q[g] <= bit_i;
          else        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  // start bit releases the break hold and takes priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        brk_q <= 1'b0;
    else if (brk_clr_i) brk_q <= 1'b0;
    else if (brk_set_i) brk_q <= 1'b1;
  end

  assign bit_o = stage_q[DEPTH-1];
  assign brk_o = brk_q;
endmodule

// File: rtl/chmode_route.sv
module chmode_route
  import uart_chmode_pkg::*;
(
  input  chmode_e mode_i,
  input  logic    echo_bit_i,
  input  logic    brk_i,
  input  logic    rx_pin_i,
  input  logic    core_tx_i,
  input  logic    tx_en_i,
  input  logic    core_tx_rdy_i,
  input  logic    core_tx_emt_i,
  output logic    tx_pin_o,
  output logic    core_rx_o,
  output logic    core_tx_en_o,
  output logic    tx_rdy_o,
  output logic    tx_emt_o,
  output logic    parity_chk_o,
  output logic    frame_chk_o,
  output logic    cpu_rx_en_o
);
  logic echoing, cpu_tx_link;

  always_comb begin
    echoing     = (mode_i == CHM_ECHO) || (mode_i == CHM_REMOTE);
    cpu_tx_link = !echoing;
    unique case (mode_i)
      CHM_NORMAL: begin tx_pin_o = core_tx_i; core_rx_o = rx_pin_i;  end
      CHM_LOCAL:  begin tx_pin_o = 1'b1;      core_rx_o = core_tx_i; end
      default:    begin tx_pin_o = brk_i ? 1'b0 : echo_bit_i; core_rx_o = rx_pin_i; end
    endcase
    core_tx_en_o = tx_en_i       && cpu_tx_link;
    tx_rdy_o     = core_tx_rdy_i && cpu_tx_link;
    tx_emt_o     = core_tx_emt_i && cpu_tx_link;
    parity_chk_o = (mode_i != CHM_REMOTE);
    frame_chk_o  = (mode_i != CHM_REMOTE);
    cpu_rx_en_o  = (mode_i != CHM_REMOTE);
  end
endmodule

// File: rtl/uart_chmode.sv
module uart_chmode
  import uart_chmode_pkg::*;
#(
  parameter int unsigned RETIME_DEPTH = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_req_i,
  input  logic       rx_idle_i,
  input  logic       tx_idle_i,
  input  logic       rx_tick_i,
  input  logic       rx_start_i,
  input  logic       rx_break_i,
  input  logic       rx_pin_i,
  output logic       tx_pin_o,
  input  logic       core_tx_i,
  output logic       core_rx_o,
  input  logic       tx_en_i,
  output logic       core_tx_en_o,
  input  logic       core_tx_rdy_i,
  input  logic       core_tx_emt_i,
  output logic       tx_rdy_o,
  output logic       tx_emt_o,
  output logic       parity_chk_o,
  output logic       frame_chk_o,
  output logic       cpu_rx_en_o,
  output logic [1:0] mode_o
);
  chmode_e mode;
  logic    echo_bit, brk;

  chmode_latch u_latch (
    .clk_i, .rst_ni,
    .req_i(mode_req_i), .rx_idle_i, .tx_idle_i,
    .mode_o(mode)
  );

  echo_retimer #(.DEPTH(RETIME_DEPTH)) u_retime (
    .clk_i, .rst_ni,
    .tick_i(rx_tick_i), .bit_i(rx_pin_i),
    .brk_set_i(rx_break_i), .brk_clr_i(rx_start_i),
    .bit_o(echo_bit), .brk_o(brk)
  );

  chmode_route u_route (
    .mode_i(mode), .echo_bit_i(echo_bit), .brk_i(brk),
    .rx_pin_i, .core_tx_i, .tx_en_i, .core_tx_rdy_i, .core_tx_emt_i,
    .tx_pin_o, .core_rx_o, .core_tx_en_o, .tx_rdy_o, .tx_emt_o,
    .parity_chk_o, .frame_chk_o, .cpu_rx_en_o
  );

  assign mode_o = mode;
endmodule

// File: rtl/uart_chmode_chk.sv
module uart_chmode_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_o,
  input logic       rx_idle_i,
  input logic       tx_idle_i,
  input logic       rx_start_i,
  input logic       rx_break_i,
  input logic       tx_pin_o,
  input logic       core_tx_i,
  input logic       core_rx_o,
  input logic       core_tx_en_o,
  input logic       tx_rdy_o,
  input logic       tx_emt_o,
  input logic       parity_chk_o,
  input logic       frame_chk_o,
  input logic       cpu_rx_en_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r1_hold_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(rx_idle_i && tx_idle_i)) |-> $stable(mode_o));

  a_r4_echo_status_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01) |-> (!tx_rdy_o && !tx_emt_o && !core_tx_en_o && cpu_rx_en_o));

  a_r5_remote_no_checks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11) |-> (!parity_chk_o && !frame_chk_o && !cpu_rx_en_o));

  a_r6_local_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10) |-> (tx_pin_o && core_rx_o == core_tx_i));

  a_r7_break_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && mode_o[0] && $past(rx_break_i && !rx_start_i)) |-> !tx_pin_o);
endmodule

bind uart_chmode uart_chmode_chk u_chk (
  .clk_i, .rst_ni, .mode_o, .rx_idle_i, .tx_idle_i, .rx_start_i, .rx_break_i,
  .tx_pin_o, .core_tx_i, .core_rx_o, .core_tx_en_o, .tx_rdy_o, .tx_emt_o,
  .parity_chk_o, .frame_chk_o, .cpu_rx_en_o
);

// File: tb/uart_chmode_tb.sv
module uart_chmode_tb;
  localparam int DEPTH = 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode_req = 0;
  logic rx_idle = 0, tx_idle = 0, rx_tick = 0, rx_start = 0, rx_break = 0;
  logic rx_pin = 1, core_tx = 1, tx_en = 0, tx_rdy_c = 0, tx_emt_c = 0;
  logic tx_pin, core_rx, core_tx_en, tx_rdy, tx_emt, par_chk, frm_chk, cpu_rx;
  logic [1:0] mode;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  uart_chmode #(.RETIME_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_req_i(mode_req),
    .rx_idle_i(rx_idle), .tx_idle_i(tx_idle), .rx_tick_i(rx_tick),
    .rx_start_i(rx_start), .rx_break_i(rx_break), .rx_pin_i(rx_pin),
    .tx_pin_o(tx_pin), .core_tx_i(core_tx), .core_rx_o(core_rx),
    .tx_en_i(tx_en), .core_tx_en_o(core_tx_en), .core_tx_rdy_i(tx_rdy_c),
    .core_tx_emt_i(tx_emt_c), .tx_rdy_o(tx_rdy), .tx_emt_o(tx_emt),
    .parity_chk_o(par_chk), .frame_chk_o(frm_chk), .cpu_rx_en_o(cpu_rx),
    .mode_o(mode)
  );

  // reference model state
  int m_mode = 0;
  bit m_brk = 0;
  bit m_chain [DEPTH] = '{default: 1'b1};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_brk = 0;
      for (int i = 0; i < DEPTH; i++) m_chain[i] = 1'b1;
    end else begin
      if (rx_idle && tx_idle) m_mode = int'(mode_req);
      if (rx_tick) begin
        for (int i = DEPTH-1; i > 0; i--) m_chain[i] = m_chain[i-1];
        m_chain[0] = rx_pin;
      end
      if (rx_start) m_brk = 0;
      else if (rx_break) m_brk = 1;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d act=%b exp=%b", tag, cyc, act, exp);
    end
  endtask

  task automatic compare();
    bit echo_m, link;
    logic e_tx, e_rx;
    echo_m = (m_mode == 1) || (m_mode == 3);
    link = !echo_m;
    n_run++;
    if (mode !== 2'(m_mode)) begin
      n_fail++;
      $display("FAIL R1 cyc=%0d mode act=%0d exp=%0d", cyc, mode, m_mode);
    end
    case (m_mode)
      0: begin e_tx = core_tx; e_rx = rx_pin; end
      2: begin e_tx = 1'b1; e_rx = core_tx; end
      default: begin e_tx = m_brk ? 1'b0 : m_chain[DEPTH-1]; e_rx = rx_pin; end
    endcase
    if (m_mode == 0)      chk("R2 tx_pin", tx_pin, e_tx);
    else if (m_mode == 2) chk("R6 tx_pin", tx_pin, e_tx);
    else if (m_brk)       chk("R7 tx_pin", tx_pin, e_tx);
    else                  chk("R3 R8 tx_pin", tx_pin, e_tx);
    chk(m_mode == 2 ? "R6 core_rx" : "R2 core_rx", core_rx, e_rx);
    chk(echo_m ? "R4 tx_en" : "R2 tx_en", core_tx_en, tx_en & link);
    chk(echo_m ? "R4 tx_rdy" : "R2 tx_rdy", tx_rdy, tx_rdy_c & link);
    chk(echo_m ? "R4 tx_emt" : "R2 tx_emt", tx_emt, tx_emt_c & link);
    chk("R5 parity_chk", par_chk, m_mode != 3);
    chk("R5 frame_chk", frm_chk, m_mode != 3);
    chk("R5 cpu_rx_en", cpu_rx, m_mode != 3);
  endtask

  task automatic drive(input int tgt, input int brk_pct);
    rx_pin   = $urandom_range(1, 0);
    core_tx  = $urandom_range(1, 0);
    rx_tick  = ($urandom_range(3, 0) == 0);
    tx_en    = $urandom_range(1, 0);
    tx_rdy_c = $urandom_range(1, 0);
    tx_emt_c = $urandom_range(1, 0);
    rx_break = ($urandom_range(99, 0) < brk_pct);
    rx_start = ($urandom_range(99, 0) < brk_pct / 2);
    rx_idle  = ($urandom_range(2, 0) != 0);
    tx_idle  = ($urandom_range(2, 0) != 0);
    mode_req = ($urandom_range(9, 0) == 0) ? 2'($urandom_range(3, 0)) : 2'(tgt);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(7));
    #5;
    // reset state (R1, R3: retime stages start at 1)
    chk("R1 reset mode", mode[0] | mode[1], 1'b0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare();
    // sweep all modes, several times with varying break density
    for (int pass = 0; pass < 3; pass++) begin
      for (int m = 0; m < 4; m++) begin
        for (int k = 0; k < 300; k++) begin
          drive(m, pass * 8);
          @(negedge clk);
          cyc++;
          compare();
        end
      end
    end
    // R7: explicit break then start in echo mode
    rx_idle = 1; tx_idle = 1; mode_req = 2'b01; rx_break = 0; rx_start = 0;
    @(negedge clk); compare();
    rx_idle = 0; rx_break = 1;
    @(negedge clk); compare();
    rx_break = 0;
    repeat (5) begin rx_pin = 1; rx_tick = 1; @(negedge clk); compare(); end
    chk("R7 break held", tx_pin, 1'b0);
    rx_start = 1; rx_break = 1;
    @(negedge clk); compare();
    chk("R7 start clears", tx_pin, 1'b1);
    rx_start = 0; rx_break = 0;
    @(negedge clk); compare();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule